// File: doc/BRIEF.md
# Active-Low Bus Parity Generator and Checker

This block produces and checks parity for two groups of active-low bus lines. The request group is the address strobe together with a five-line request code. The response group is the three response status lines. The parity rule counts asserted (low) lines rather than high bits. A parity line reads high when the number of low covered lines is even, and low when it is odd. So a group with every line deasserted carries high parity.

Three role selects decide what the block does. With the request generator role on, it drives request parity. With the response generator role on, it drives response parity. With the observer role on, it compares the incoming parity pins against the covered lines. A mismatch sets a sticky error flag for the group concerned. The flag stays set until a synchronous clear input or reset removes it.

The response status is idle when all three lines are deasserted. Nobody drives parity then, so the response is never checked in that state. Request parity is checked only in a cycle where the address strobe is low.

Top module: `bus_parity_unit`

## Requirements
- R1: After reset, `req_par_o` and `rsp_par_o` are 1, and `req_err_o` and `rsp_err_o` are 0.
- R2: With `gen_req_i` = 1, `req_par_o` after a rising edge reflects the strobe and request code sampled at that edge. It is 1 when the number of 0s among those six lines is even, and 0 when that number is odd.
- R3: With `gen_rsp_i` = 1, `rsp_par_o` after a rising edge reflects the three status lines sampled at that edge. It is 1 when the number of 0s among them is even, and 0 when that number is odd.
- R4: With `obs_en_i` = 1 and `strb_n_i` = 0, a `req_par_i` that differs from the R2 value of the sampled lines sets `req_err_o` at that edge.
- R5: The request group is not checked while `strb_n_i` = 1. A wrong `req_par_i` in such a cycle leaves `req_err_o` at 0.
- R6: With `obs_en_i` = 1 and `stat_n_i` not equal to 3'b111, a `rsp_par_i` that differs from the R3 value sets `rsp_err_o` at that edge.
- R7: When `stat_n_i` = 3'b111 (idle, no agent driving), no response error is flagged, whatever the value of `rsp_par_i`.
- R8: Once set, an error flag stays 1 until a rising edge with `err_clr_i` = 1 clears it. If a new mismatch for the same group is sampled at that same edge, the flag stays 1.
- R9: With `obs_en_i` = 0, neither error flag is set.
- R10: A generator whose role select is 0 holds its parity output at 1.
- R11: The two groups are independent. A request mismatch leaves `rsp_err_o` unchanged, and a response mismatch leaves `req_err_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_req_i | input | 1 | Request generator role select |
| gen_rsp_i | input | 1 | Response generator role select |
| obs_en_i | input | 1 | Observer (checker) role select |
| err_clr_i | input | 1 | Synchronous clear of both error flags |
| strb_n_i | input | 1 | Address strobe, active low |
| req_n_i | input | 5 | Request code lines, active low |
| stat_n_i | input | 3 | Response status lines, active low; 3'b111 means idle |
| req_par_i | input | 1 | Incoming request parity pin |
| rsp_par_i | input | 1 | Incoming response parity pin |
| req_par_o | output | 1 | Generated request parity |
| rsp_par_o | output | 1 | Generated response parity |
| req_err_o | output | 1 | Sticky request parity error |
| rsp_err_o | output | 1 | Sticky response parity error |

## Verification
Some behaviours are checked by assertions on every clock cycle:
- the one-cycle relation between the sampled lines and each generated parity output;
- the setting of each flag on a sampled mismatch;
- the absence of any flag while the observer is off or the status is idle;
- the persistence of a flag until a clear.

Other behaviours only the bench scenarios show:
- that the parity definition itself matches the rule counting low lines, over chosen patterns including all-deasserted and all-asserted groups;
- that a wrong parity during a deasserted strobe is ignored;
- that a clear and a fresh mismatch at the same edge leave the flag set.

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int REQ_W  = 5,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_req_i,
  input  logic              gen_rsp_i,
  input  logic              obs_en_i,
  input  logic              err_clr_i,
  input  logic              strb_n_i,
  input  logic [REQ_W-1:0]  req_n_i,
  input  logic [STAT_W-1:0] stat_n_i,
  input  logic              req_par_i,
  input  logic              rsp_par_i,
  output logic              req_par_o,
  output logic              rsp_par_o,
  output logic              req_err_o,
  output logic              rsp_err_o
);

  localparam int REQ_GRP_W = REQ_W + 1;

  logic [REQ_GRP_W-1:0] req_grp;
  logic req_good, rsp_good, rsp_busy, req_bad, rsp_bad;

  assign req_grp  = {strb_n_i, req_n_i};

  // parity is high for an even number of low lines
  assign req_good = ~(^(~req_grp));
  assign rsp_good = ~(^(~stat_n_i));
  assign rsp_busy = stat_n_i != {STAT_W{1'b1}};

  assign req_bad  = obs_en_i && !strb_n_i && (req_par_i != req_good);
  assign rsp_bad  = obs_en_i && rsp_busy && (rsp_par_i != rsp_good);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_par_o <= 1'b1;
      rsp_par_o <= 1'b1;
    end else begin
      req_par_o <= gen_req_i ? req_good : 1'b1;
      rsp_par_o <= gen_rsp_i ? rsp_good : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_err_o <= 1'b0;
      rsp_err_o <= 1'b0;
    end else begin
      req_err_o <= req_bad || (req_err_o && !err_clr_i);
      rsp_err_o <= rsp_bad || (rsp_err_o && !err_clr_i);
    end
  end

endmodule

module bus_parity_unit_chk #(
  parameter int REQ_W  = 5,
  parameter int STAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gen_req_i,
  input logic              gen_rsp_i,
  input logic              obs_en_i,
  input logic              err_clr_i,
  input logic              strb_n_i,
  input logic [REQ_W-1:0]  req_n_i,
  input logic [STAT_W-1:0] stat_n_i,
  input logic              req_par_i,
  input logic              rsp_par_i,
  input logic              req_par_o,
  input logic              rsp_par_o,
  input logic              req_err_o,
  input logic              rsp_err_o
);

  logic req_even, rsp_even;
  assign req_even = ($countones(~{strb_n_i, req_n_i}) % 2) == 0;
  assign rsp_even = ($countones(~stat_n_i) % 2) == 0;

  // R2
  req_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_req_i |=> req_par_o == $past(req_even));

  // R3
  rsp_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_rsp_i |=> rsp_par_o == $past(rsp_even));

  // R4
  req_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_en_i && !strb_n_i && req_par_i != req_even) |=> req_err_o);

  // R6
  rsp_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_en_i && !(&stat_n_i) && rsp_par_i != rsp_even) |=> rsp_err_o);

  // R7
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_err_o && (&stat_n_i)) |=> !rsp_err_o);

  // R8
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_err_o && !err_clr_i) |=> req_err_o);

  // R8
  rsp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err_o && !err_clr_i) |=> rsp_err_o);

  // R9
  obs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!obs_en_i && err_clr_i) |=> (!req_err_o && !rsp_err_o));

  // R10
  req_idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_req_i |=> req_par_o);

  // R10
  rsp_idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_rsp_i |=> rsp_par_o);

endmodule

bind bus_parity_unit bus_parity_unit_chk #(.REQ_W(REQ_W), .STAT_W(STAT_W)) i_chk (.*);

// File: tb/test_bus_parity_unit.sv
module test_bus_parity_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_req, gen_rsp, obs_en, err_clr, strb_n, req_par_in, rsp_par_in;
  logic [4:0] req_n;
  logic [2:0] stat_n;
  logic req_par_out, rsp_par_out, req_err, rsp_err;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bus_parity_unit i_bus_parity_unit (
    .clk(clk), .rst_n(rst_n), .gen_req_i(gen_req), .gen_rsp_i(gen_rsp),
    .obs_en_i(obs_en), .err_clr_i(err_clr), .strb_n_i(strb_n), .req_n_i(req_n),
    .stat_n_i(stat_n), .req_par_i(req_par_in), .rsp_par_i(rsp_par_in),
    .req_par_o(req_par_out), .rsp_par_o(rsp_par_out),
    .req_err_o(req_err), .rsp_err_o(rsp_err));

  function automatic logic even_lows(input logic [7:0] v, input int n);
    int lows = 0;
    for (int i = 0; i < n; i++) if (!v[i]) lows++;
    return (lows % 2) == 0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic clear_all;
    obs_en = 1'b0; err_clr = 1'b1; step(); err_clr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 req_par", req_par_out, 1'b1);
    check("R1 rsp_par", rsp_par_out, 1'b1);
    check("R1 req_err", req_err, 1'b0);
    check("R1 rsp_err", rsp_err, 1'b0);
  endtask

  task automatic t_gen_req;
    logic [5:0] pats [5] = '{6'b111111, 6'b000000, 6'b011111, 6'b101010, 6'b110001};
    gen_req = 1'b1;
    foreach (pats[k]) begin
      {strb_n, req_n} = pats[k];
      step();
      check("R2 req_par_o", req_par_out, even_lows({2'b11, pats[k]}, 6));
    end
    gen_req = 1'b0; {strb_n, req_n} = 6'b111111; step();
    check("R10 req_par_o idle", req_par_out, 1'b1);
  endtask

  task automatic t_gen_rsp;
    gen_rsp = 1'b1;
    for (int s = 0; s < 8; s++) begin
      stat_n = 3'(s);
      step();
      check("R3 rsp_par_o", rsp_par_out, even_lows({5'b11111, 3'(s)}, 3));
    end
    gen_rsp = 1'b0; stat_n = 3'b010; step();
    check("R10 rsp_par_o idle", rsp_par_out, 1'b1);
    stat_n = 3'b111;
  endtask

  task automatic t_req_check;
    obs_en = 1'b1;
    strb_n = 1'b1; req_n = 5'b00000; req_par_in = 1'b0; step();
    check("R5 strobe high ignored", req_err, 1'b0);
    strb_n = 1'b0; req_n = 5'b11110; req_par_in = 1'b1; step();
    check("R4 correct parity no error", req_err, 1'b0);
    req_par_in = 1'b0; step();
    check("R4 mismatch flags", req_err, 1'b1);
    check("R11 rsp_err untouched", rsp_err, 1'b0);
    strb_n = 1'b1; req_par_in = 1'b1; step();
    check("R8 req_err sticky", req_err, 1'b1);
    err_clr = 1'b1; step(); err_clr = 1'b0;
    check("R8 req_err cleared", req_err, 1'b0);
  endtask

  task automatic t_rsp_check;
    obs_en = 1'b1;
    stat_n = 3'b111; rsp_par_in = 1'b0; step();
    check("R7 idle not flagged", rsp_err, 1'b0);
    stat_n = 3'b100; rsp_par_in = 1'b1; step();
    check("R6 correct parity no error", rsp_err, 1'b0);
    stat_n = 3'b110; rsp_par_in = 1'b1; step();
    check("R6 mismatch flags", rsp_err, 1'b1);
    check("R11 req_err untouched", req_err, 1'b0);
    err_clr = 1'b1; step(); err_clr = 1'b0;
    check("R8 clear with new mismatch keeps flag", rsp_err, 1'b1);
    stat_n = 3'b111; clear_all();
    check("R8 rsp_err cleared", rsp_err, 1'b0);
  endtask

  task automatic t_obs_off;
    obs_en = 1'b0;
    strb_n = 1'b0; req_n = 5'b00000; req_par_in = 1'b0;
    stat_n = 3'b000; rsp_par_in = 1'b1; step();
    check("R9 req_err off", req_err, 1'b0);
    check("R9 rsp_err off", rsp_err, 1'b0);
    strb_n = 1'b1; stat_n = 3'b111;
  endtask

  initial begin
    gen_req = 0; gen_rsp = 0; obs_en = 0; err_clr = 0;
    strb_n = 1; req_n = '1; stat_n = '1; req_par_in = 1; rsp_par_in = 1;
    step(); step(); rst_n = 1'b1; step();
    t_reset();
    t_gen_req();
    t_gen_rsp();
    t_req_check();
    t_rsp_check();
    t_obs_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule